// File: doc/BRIEF.md
# Temperature Limit Monitor and Extremes Recorder

This block watches a stream of signed temperature samples, each in units of 1/256 degree Celsius. Every accepted sample updates a running highest and a running lowest reading. The sample is also compared against two pairs of thresholds. One pair raises an interrupt. The other pair requests a system reset. Crossings set sticky flags for over-temperature, under-temperature and interrupt. Software clears these flags with write-one-to-clear pulses, and it can clear each extreme recorder on its own.

Samples enter on a valid/ready channel. The monitor never applies back-pressure: `smp_ready` rises on the first clock edge after reset and stays high. A sample is taken on every edge where `smp_valid` and `smp_ready` are both high. The data bus carries no meaning while `smp_valid` is low. The limits, the enables and the clear pulses are plain level or pulse inputs. Every result is registered, so each result appears after the clock edge that accepts the sample.

Top module: `temp_limit_monitor`

## Requirements
- R1: The high recorder holds the largest accepted sample, compared as signed, since its last clear or since reset.
- R2: The low recorder holds the smallest accepted sample, compared as signed, since its last clear or since reset.
- R3: A pulse on `clr_hi_rec` returns the high recorder to the most negative code (0x8000 at 16 bits). A pulse on `clr_lo_rec` returns the low recorder to the most positive code (0x7FFF). Each clear leaves the other recorder unchanged. The next sample therefore loads the cleared recorder directly. Reset places both recorders at these cleared values.
- R4: When `cmp_hi_en` is high, a sample strictly greater than `irq_hi_lim` or than `rst_hi_lim` sets `over_flag`. A sample equal to a limit does not set it.
- R5: When `cmp_lo_en` is high, a sample strictly less than `irq_lo_lim` or than `rst_lo_lim` sets `under_flag`. All comparisons are signed.
- R6: While a compare enable is low, crossings in that direction set no flag and cause no reset request. The recorders keep updating.
- R7: An enabled crossing of either interrupt limit sets the sticky `irq_flag`. `irq_out` equals `irq_flag` gated by `irq_en`.
- R8: An enabled crossing of either reset limit while `rst_en` is high gives a one-cycle `rst_req` pulse after the accepting edge. With `rst_en` low there is no pulse.
- R9: The flags are sticky. `clr_over`, `clr_under` and `clr_irq` each clear only their own flag. When a set and a clear land in the same cycle, the set wins.
- R10: After reset `smp_ready` is high. A cycle with `smp_valid` low changes neither the recorders nor the flags, whatever is on `smp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, high once out of reset |
| smp_data | input | TEMP_W | Signed temperature sample |
| irq_hi_lim | input | TEMP_W | Upper limit for the interrupt |
| irq_lo_lim | input | TEMP_W | Lower limit for the interrupt |
| rst_hi_lim | input | TEMP_W | Upper limit for the reset request |
| rst_lo_lim | input | TEMP_W | Lower limit for the reset request |
| cmp_hi_en | input | 1 | Enables the upper-limit comparisons |
| cmp_lo_en | input | 1 | Enables the lower-limit comparisons |
| irq_en | input | 1 | Interrupt output enable |
| rst_en | input | 1 | Reset request enable |
| clr_over | input | 1 | Write-one-to-clear pulse for the over-temperature flag |
| clr_under | input | 1 | Write-one-to-clear pulse for the under-temperature flag |
| clr_irq | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| clr_hi_rec | input | 1 | Clear pulse for the high recorder |
| clr_lo_rec | input | 1 | Clear pulse for the low recorder |
| hi_rec | output | TEMP_W | Highest sample recorded |
| lo_rec | output | TEMP_W | Lowest sample recorded |
| over_flag | output | 1 | Sticky over-temperature flag |
| under_flag | output | 1 | Sticky under-temperature flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_out | output | 1 | Interrupt output |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The hardest case to reach from the ports is a clear that arrives in the same cycle as a crossing that would set the same flag or recorder. To reach it, the stimulus raises a flag first. It then drives the clear pulse and a sample that crosses the limit again on one edge, and checks that the flag is still set. The limit-equality case and the two recorder reload cases are reached the same way, by picking sample values exactly on or just past the programmed limits.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic {REC_HIGH = 1'b0, REC_LOW = 1'b1} rec_kind_e;
  localparam int NUM_FLAGS = 3;
  localparam int FL_OVER  = 0;
  localparam int FL_UNDER = 1;
  localparam int FL_IRQ   = 2;
endpackage

// File: rtl/tlm_extreme_rec.sv
module tlm_extreme_rec
  import tlm_pkg::*;
#(
  parameter int        W    = 16,
  parameter rec_kind_e KIND = REC_HIGH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] sample,
  input  logic         clr,
  output logic [W-1:0] rec
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] INIT     = (KIND == REC_HIGH) ? MOST_NEG : MOST_POS;

  logic beats;
  generate
    if (KIND == REC_HIGH) begin : g_high
      assign beats = $signed(sample) > $signed(rec);
    end else begin : g_low
      assign beats = $signed(sample) < $signed(rec);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rec <= INIT;
    else if (upd && (clr || beats)) rec <= sample;
    else if (clr)                rec <= INIT;
  end

  // R1 R2
  rec_bounds_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((KIND == REC_HIGH) ? ($signed(rec) >= $signed($past(sample)))
                                : ($signed(rec) <= $signed($past(sample)))));
endmodule

// File: rtl/tlm_limit_cmp.sv
module tlm_limit_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] sample,
  input  logic [W-1:0] hi_lim,
  input  logic [W-1:0] lo_lim,
  input  logic         hi_en,
  input  logic         lo_en,
  output logic         above,
  output logic         below
);
  always_comb begin
    above = hi_en && ($signed(sample) > $signed(hi_lim));
    below = lo_en && ($signed(sample) < $signed(lo_lim));
  end
endmodule

// File: rtl/tlm_sticky_flags.sv
module tlm_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag[i] <= 1'b0;
        else if (set[i]) flag[i] <= 1'b1;
        else if (clr[i]) flag[i] <= 1'b0;
      end

      // R9
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[i] && !clr[i]) |=> flag[i]);
      // R9
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !flag[i]);
      // R9
      flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> flag[i]);
    end
  endgenerate
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
  import tlm_pkg::*;
#(
  parameter int TEMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [TEMP_W-1:0] smp_data,
  input  logic [TEMP_W-1:0] irq_hi_lim,
  input  logic [TEMP_W-1:0] irq_lo_lim,
  input  logic [TEMP_W-1:0] rst_hi_lim,
  input  logic [TEMP_W-1:0] rst_lo_lim,
  input  logic              cmp_hi_en,
  input  logic              cmp_lo_en,
  input  logic              irq_en,
  input  logic              rst_en,
  input  logic              clr_over,
  input  logic              clr_under,
  input  logic              clr_irq,
  input  logic              clr_hi_rec,
  input  logic              clr_lo_rec,
  output logic [TEMP_W-1:0] hi_rec,
  output logic [TEMP_W-1:0] lo_rec,
  output logic              over_flag,
  output logic              under_flag,
  output logic              irq_flag,
  output logic              irq_out,
  output logic              rst_req
);
  localparam int NPAIR = 2;
  localparam int P_IRQ = 0;
  localparam int P_RST = 1;

  logic upd;
  logic [NPAIR-1:0][TEMP_W-1:0] hi_lims, lo_lims;
  logic [NPAIR-1:0] above, below;
  logic [NUM_FLAGS-1:0] fset, fclr, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_ready <= 1'b0;
    else        smp_ready <= 1'b1;
  end

  assign upd = smp_valid && smp_ready;

  assign hi_lims[P_IRQ] = irq_hi_lim;
  assign lo_lims[P_IRQ] = irq_lo_lim;
  assign hi_lims[P_RST] = rst_hi_lim;
  assign lo_lims[P_RST] = rst_lo_lim;

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      tlm_limit_cmp #(.W(TEMP_W)) u_cmp (
        .sample(smp_data), .hi_lim(hi_lims[p]), .lo_lim(lo_lims[p]),
        .hi_en(cmp_hi_en), .lo_en(cmp_lo_en),
        .above(above[p]), .below(below[p])
      );
    end
  endgenerate

  tlm_extreme_rec #(.W(TEMP_W), .KIND(REC_HIGH)) u_hi_rec (
    .clk(clk), .rst_n(rst_n), .upd(upd), .sample(smp_data),
    .clr(clr_hi_rec), .rec(hi_rec)
  );

  tlm_extreme_rec #(.W(TEMP_W), .KIND(REC_LOW)) u_lo_rec (
    .clk(clk), .rst_n(rst_n), .upd(upd), .sample(smp_data),
    .clr(clr_lo_rec), .rec(lo_rec)
  );

  always_comb begin
    fset[FL_OVER]  = upd && (|above);
    fset[FL_UNDER] = upd && (|below);
    fset[FL_IRQ]   = upd && (above[P_IRQ] || below[P_IRQ]);
    fclr[FL_OVER]  = clr_over;
    fclr[FL_UNDER] = clr_under;
    fclr[FL_IRQ]   = clr_irq;
  end

  tlm_sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .flag(flags)
  );

  assign over_flag  = flags[FL_OVER];
  assign under_flag = flags[FL_UNDER];
  assign irq_flag   = flags[FL_IRQ];
  assign irq_out    = irq_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= upd && rst_en && (above[P_RST] || below[P_RST]);
  end

  // R8
  rst_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(smp_valid) && $past(rst_en)));
  // R6
  no_over_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_hi_en && !over_flag && !clr_over) |=> !over_flag);
  // R10
  ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> smp_ready);
endmodule

// File: tb/temp_limit_monitor_bench.sv
module temp_limit_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] t;
    logic [W-1:0] emax;
    logic [W-1:0] emin;
    logic eo, eu, ei;
  } vec_t;

  // limits: irq hi 0x1900, irq lo 0x0000, rst hi 0x3200, rst lo 0xF600
  localparam vec_t VECS [6] = '{
    '{16'h1000, 16'h1000, 16'h1000, 1'b0, 1'b0, 1'b0},
    '{16'h1900, 16'h1900, 16'h1000, 1'b0, 1'b0, 1'b0},
    '{16'h0800, 16'h1900, 16'h0800, 1'b0, 1'b0, 1'b0},
    '{16'h1901, 16'h1901, 16'h0800, 1'b1, 1'b0, 1'b1},
    '{16'hFF00, 16'h1901, 16'hFF00, 1'b1, 1'b1, 1'b1},
    '{16'h0500, 16'h1901, 16'hFF00, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_ready;
  logic [W-1:0] smp_data = '0;
  logic [W-1:0] irq_hi_lim = 16'h1900, irq_lo_lim = 16'h0000;
  logic [W-1:0] rst_hi_lim = 16'h3200, rst_lo_lim = 16'hF600;
  logic cmp_hi_en = 1, cmp_lo_en = 1, irq_en = 1, rst_en = 0;
  logic clr_over = 0, clr_under = 0, clr_irq = 0, clr_hi_rec = 0, clr_lo_rec = 0;
  logic [W-1:0] hi_rec, lo_rec;
  logic over_flag, under_flag, irq_flag, irq_out, rst_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_limit_monitor #(.TEMP_W(W)) u_temp_limit_monitor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .irq_hi_lim(irq_hi_lim), .irq_lo_lim(irq_lo_lim),
    .rst_hi_lim(rst_hi_lim), .rst_lo_lim(rst_lo_lim), .cmp_hi_en(cmp_hi_en),
    .cmp_lo_en(cmp_lo_en), .irq_en(irq_en), .rst_en(rst_en),
    .clr_over(clr_over), .clr_under(clr_under), .clr_irq(clr_irq),
    .clr_hi_rec(clr_hi_rec), .clr_lo_rec(clr_lo_rec), .hi_rec(hi_rec),
    .lo_rec(lo_rec), .over_flag(over_flag), .under_flag(under_flag),
    .irq_flag(irq_flag), .irq_out(irq_out), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    smp_valid = 0; clr_over = 0; clr_under = 0; clr_irq = 0;
    clr_hi_rec = 0; clr_lo_rec = 0;
  endtask

  task automatic send(input logic [W-1:0] t);
    smp_data = t; smp_valid = 1;
    step();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    // reset state R3 R9
    chk("R3 reset hi", hi_rec, 16'h8000);
    chk("R3 reset lo", lo_rec, 16'h7FFF);
    chk("R9 reset flags", {over_flag, under_flag, irq_flag, rst_req}, 0);
    rst_n = 1;
    step();
    chk("R10 ready", smp_ready, 1);

    for (int i = 0; i < 6; i++) begin
      send(VECS[i].t);
      chk($sformatf("R1 vec%0d hi", i), hi_rec, VECS[i].emax);
      chk($sformatf("R2 vec%0d lo", i), lo_rec, VECS[i].emin);
      chk($sformatf("R4 vec%0d over", i), over_flag, VECS[i].eo);
      chk($sformatf("R5 vec%0d under", i), under_flag, VECS[i].eu);
      chk($sformatf("R7 vec%0d irq", i), {irq_flag, irq_out}, {VECS[i].ei, VECS[i].ei});
      chk($sformatf("R8 vec%0d no rst", i), rst_req, 0);
    end

    // R10 idle cycle with extreme data
    smp_data = 16'h7000; smp_valid = 0;
    @(posedge clk); #1;
    chk("R10 idle hi", hi_rec, 16'h1901);
    chk("R10 idle flags", {over_flag, under_flag, irq_flag}, 3'b111);

    // R9 clear only over
    clr_over = 1; step();
    chk("R9 clr over", {over_flag, under_flag, irq_flag}, 3'b011);

    // R3 clear high recorder alone
    clr_hi_rec = 1; step();
    chk("R3 clr hi", hi_rec, 16'h8000);
    chk("R3 lo kept", lo_rec, 16'hFF00);
    send(16'h0100);
    chk("R3 reload hi", hi_rec, 16'h0100);
    chk("R3 lo stays", lo_rec, 16'hFF00);

    // R3 clear low with same-cycle sample loads it
    clr_lo_rec = 1; send(16'h0200);
    chk("R3 lo reload same cycle", lo_rec, 16'h0200);

    // R9 set wins over clear
    clr_irq = 1; clr_over = 1; send(16'h2000);
    chk("R9 set wins", {over_flag, irq_flag}, 2'b11);

    // R7 gate
    irq_en = 0; #1;
    chk("R7 irq gated", {irq_flag, irq_out}, 2'b10);
    irq_en = 1;

    // R8 reset request pulse
    rst_en = 1; send(16'h3300);
    chk("R8 pulse", rst_req, 1);
    step();
    chk("R8 pulse ends", rst_req, 0);
    send(16'hF500);
    chk("R8 low pulse", rst_req, 1);
    rst_en = 0; send(16'h3300);
    chk("R8 disabled", rst_req, 0);

    // R6 compare enables off
    clr_over = 1; clr_under = 1; clr_irq = 1; step();
    cmp_hi_en = 0; cmp_lo_en = 0; rst_en = 1;
    send(16'h4000);
    chk("R6 hi off flags", {over_flag, irq_flag, rst_req}, 0);
    chk("R6 hi rec updates", hi_rec, 16'h4000);
    send(16'hE000);
    chk("R6 lo off flags", {under_flag, irq_flag, rst_req}, 0);
    chk("R6 lo rec updates", lo_rec, 16'hE000);

    // R5 via reset-lower limit only
    cmp_lo_en = 1; rst_en = 0; irq_lo_lim = 16'h8000;
    send(16'hF5FF);
    chk("R5 rst lo sets under", {under_flag, irq_flag}, 2'b10);

    done = 1;
    finish_run();
  end
endmodule